// File: doc/BRIEF.md
# Processor Clock and Reset Generator

This block derives a processor clock and a slower peripheral clock from one of two reference sources, and produces a processor reset that is aligned to the processor clock. Everything runs on a single fast system clock. The two reference sources arrive as single-cycle enable pulses (ticks). The generated clocks are delivered as registered levels, together with one-cycle strobes that mark their edges, so that downstream logic can use them as clock enables.

A source-select pin chooses the reference. The selected ticks drive a divide-by-3 counter that forms the processor clock. A cascaded divide-by-2 stage, advanced by each processor clock period, forms the peripheral clock at one sixth of the reference rate. An active-low reset request is synchronised through a two-stage register chain. It is then loaded into the reset output only when the processor clock falls, so a processor that samples reset on the rising edge always sees a settled value. An inverted copy of the selected tick stream is also provided.

Top module: `clkrst_gen`

## Requirements
- R1: When src_sel_i is 0, only osc_tick_i advances the dividers. When it is 1, only ext_tick_i advances them. Ticks on the unselected input have no effect on any output.
- R2: Selected ticks are counted modulo 3, starting from 0 at reset. On the tick that completes a count of 3, cpu_clk_o goes high. It drops on the next selected tick, so the processor clock is high for one third of its period. Outputs change at the system clock edge that samples the tick.
- R3: The peripheral divider counts processor clock rising edges modulo 2, starting from 0 at reset. per_clk_o goes high on every second processor rising edge and stays high for one full processor clock period, which gives a period of six selected ticks and a 50% duty cycle.
- R4: cpu_rise_o, cpu_fall_o, per_rise_o and per_fall_o are one-cycle pulses. Each is high exactly in the cycle where the matching level output first shows its new value.
- R5: cpu_rst_o changes only in a cycle where cpu_fall_o is high. At that edge it takes the value of the request as it stood at the end of the two-stage synchroniser (active high: 1 means the processor is held in reset).
- R6: While rst_req_ni is held low, cpu_rst_o is high before a fifth cpu_rise_o pulse has occurred.
- R7: osc_n_o is the inverse of the selected tick input, combinationally: it is 0 exactly in the cycles where the selected source pulses.
- R8: Changing src_sel_i does not clear either divider. The next tick from the newly selected source continues the count where it stopped.
- R9: While rst_ni is low, cpu_clk_o, per_clk_o and all four strobes are 0, cpu_rst_o is 1, and both divider counts are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| osc_tick_i | input | 1 | Oscillator reference tick, one cycle wide |
| ext_tick_i | input | 1 | External-frequency reference tick, one cycle wide |
| src_sel_i | input | 1 | Reference select: 0 oscillator, 1 external |
| rst_req_ni | input | 1 | Asynchronous active-low processor reset request |
| osc_n_o | output | 1 | Inverted copy of the selected tick |
| cpu_clk_o | output | 1 | Processor clock level (1/3 of reference) |
| cpu_rise_o | output | 1 | Strobe: processor clock just went high |
| cpu_fall_o | output | 1 | Strobe: processor clock just went low |
| per_clk_o | output | 1 | Peripheral clock level (1/6 of reference) |
| per_rise_o | output | 1 | Strobe: peripheral clock just went high |
| per_fall_o | output | 1 | Strobe: peripheral clock just went low |
| cpu_rst_o | output | 1 | Processor reset, active high, updated on processor clock falls |

## Verification
The bench switches the source select in the middle of a count. A design that clears its counters on a switch would move the next processor rising edge later than expected. It also sends ticks on the unselected input alone, which a wrong multiplexer would count. It asserts and releases the reset request at points that are not aligned to processor clock falls. A reset register that follows the synchroniser directly would change cpu_rst_o outside a fall strobe. A design with an extra stage in the path would miss the exact cycle or the four-clock bound. Random tick densities check that the 1/3 and 1/2 duty cycles and their edge strobes track the selected ticks rather than system clock cycles.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
  // Registered view of one divided clock: its level and edge strobes.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } clk_view_t;
endpackage

// File: rtl/clkrst_src_mux.sv
module clkrst_src_mux (
  input  logic src_sel_i,
  input  logic osc_tick_i,
  input  logic ext_tick_i,
  output logic tick_o,
  output logic osc_n_o
);
  always_comb begin
    tick_o  = src_sel_i ? ext_tick_i : osc_tick_i;
    osc_n_o = ~tick_o;
  end
endmodule

// File: rtl/clkrst_div.sv
module clkrst_div
  import clkrst_pkg::*;
#(
  parameter int unsigned DIV = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  output clk_view_t view_o,
  output logic      wrap_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  clk_view_t     view_q;

  assign wrap_o = tick_i && (cnt_q == LAST);
  assign view_o = view_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      view_q <= '0;
    end else begin
      view_q.rise <= wrap_o;
      view_q.fall <= tick_i && view_q.level;
      if (tick_i) begin
        cnt_q        <= wrap_o ? '0 : cnt_q + 1'b1;
        view_q.level <= wrap_o;
      end
    end
  end

  // R2: level is high for exactly one input tick interval
  assert_high_one_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (view_q.level && tick_i) |=> !view_q.level);

  // R1: without an input tick the divided clock holds
  assert_hold_no_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(view_q.level));

  // R4: strobes accompany level changes and last one cycle
  assert_rise_marks_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(view_q.level) |-> view_q.rise);
  assert_fall_marks_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(view_q.level) |-> view_q.fall);
  assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    view_q.rise |=> !view_q.rise);
endmodule

// File: rtl/clkrst_rst_sync.sv
module clkrst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic upd_i,
  output logic rst_o
);
  logic [STAGES-1:0] sync_q;
  logic              rst_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q[s] <= 1'b1;
      end else if (s == 0) begin
        sync_q[s] <= ~req_ni;
      end else begin
        sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
    end else if (upd_i) begin
      rst_q <= sync_q[STAGES-1];
    end
  end

  assign rst_o = rst_q;

  // R5: output moves only after an update request
  assert_rst_moves_on_upd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(rst_q));
endmodule

// File: rtl/clkrst_gen.sv
module clkrst_gen
  import clkrst_pkg::*;
#(
  parameter int unsigned CPU_DIV     = 3,
  parameter int unsigned PER_DIV     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic ext_tick_i,
  input  logic src_sel_i,
  input  logic rst_req_ni,
  output logic osc_n_o,
  output logic cpu_clk_o,
  output logic cpu_rise_o,
  output logic cpu_fall_o,
  output logic per_clk_o,
  output logic per_rise_o,
  output logic per_fall_o,
  output logic cpu_rst_o
);
  logic      src_tick;
  logic      cpu_wrap;
  logic      per_wrap;
  logic      cpu_fall_evt;
  clk_view_t cpu_view;
  clk_view_t per_view;

  clkrst_src_mux u_mux (
    .src_sel_i  (src_sel_i),
    .osc_tick_i (osc_tick_i),
    .ext_tick_i (ext_tick_i),
    .tick_o     (src_tick),
    .osc_n_o    (osc_n_o)
  );

  clkrst_div #(.DIV(CPU_DIV)) u_cpu_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (src_tick),
    .view_o (cpu_view),
    .wrap_o (cpu_wrap)
  );

  clkrst_div #(.DIV(PER_DIV)) u_per_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (cpu_wrap),
    .view_o (per_view),
    .wrap_o (per_wrap)
  );

  // falling edge of the processor clock happens on this cycle's edge
  assign cpu_fall_evt = src_tick && cpu_view.level;

  clkrst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (rst_req_ni),
    .upd_i  (cpu_fall_evt),
    .rst_o  (cpu_rst_o)
  );

  assign cpu_clk_o  = cpu_view.level;
  assign cpu_rise_o = cpu_view.rise;
  assign cpu_fall_o = cpu_view.fall;
  assign per_clk_o  = per_view.level;
  assign per_rise_o = per_view.rise;
  assign per_fall_o = per_view.fall;

  // latency watch: processor rising edges seen while a request waits
  logic [2:0] pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (rst_req_ni || cpu_rst_o) begin
      pend_q <= '0;
    end else if (cpu_rise_o && pend_q != 3'd7) begin
      pend_q <= pend_q + 3'd1;
    end
  end

  // R6: reset reaches the processor before a fifth rising edge
  assert_rst_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= 3'd4);

  // R5: reset output changes only together with a fall strobe
  assert_rst_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cpu_rst_o) |-> cpu_fall_o);

  // R3: peripheral clock edges coincide with processor rising edges
  assert_per_edge_on_cpu_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_rise_o || per_fall_o) |-> cpu_rise_o);

  // R4: a processor clock edge strobe is never both at once
  assert_cpu_strobes_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cpu_rise_o, cpu_fall_o}) <= 1);

  logic unused_wrap;
  assign unused_wrap = per_wrap;
endmodule

// File: tb/clkrst_gen_tb_top.sv
module clkrst_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc = 1'b0, ext = 1'b0, sel = 1'b0, req_n = 1'b1;
  logic osc_n, cclk, crise, cfall, pclk, prise, pfall, crst;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // model state
  int  m_cnt, m_pcnt;
  bit  m_clk, m_rise, m_fall, m_per, m_prise, m_pfall, m_rst, m_s1, m_s2;

  always #4 clk = ~clk;

  clkrst_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc), .ext_tick_i(ext),
    .src_sel_i(sel), .rst_req_ni(req_n), .osc_n_o(osc_n),
    .cpu_clk_o(cclk), .cpu_rise_o(crise), .cpu_fall_o(cfall),
    .per_clk_o(pclk), .per_rise_o(prise), .per_fall_o(pfall), .cpu_rst_o(crst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_pcnt = 0; m_clk = 0; m_rise = 0; m_fall = 0;
    m_per = 0; m_prise = 0; m_pfall = 0; m_rst = 1; m_s1 = 1; m_s2 = 1;
  endtask

  function automatic bit sel_tick(input bit s, input bit o, input bit e);
    return s ? e : o;
  endfunction

  task automatic model_step(input bit t, input bit rq_n);
    bit old_clk, old_s2, wrap, pwrap;
    old_clk = m_clk; old_s2 = m_s2;
    wrap = t && (m_cnt == 2);
    m_rise = wrap;
    m_fall = t && old_clk;
    if (t) begin
      m_cnt = wrap ? 0 : m_cnt + 1;
      m_clk = wrap;
    end
    pwrap = wrap && (m_pcnt == 1);
    m_prise = pwrap;
    m_pfall = wrap && m_per;
    if (wrap) begin
      m_pcnt = pwrap ? 0 : m_pcnt + 1;
      m_per = pwrap;
    end
    if (t && old_clk) m_rst = old_s2;
    m_s2 = m_s1;
    m_s1 = ~rq_n;
  endtask

  task automatic compare_all();
    chk(cclk == m_clk,   "R2 cpu_clk",  cclk,  m_clk);
    chk(crise == m_rise, "R4 cpu_rise", crise, m_rise);
    chk(cfall == m_fall, "R4 cpu_fall", cfall, m_fall);
    chk(pclk == m_per,   "R3 per_clk",  pclk,  m_per);
    chk(prise == m_prise,"R4 per_rise", prise, m_prise);
    chk(pfall == m_pfall,"R4 per_fall", pfall, m_pfall);
    chk(crst == m_rst,   "R5 cpu_rst",  crst,  m_rst);
  endtask

  // one system cycle: drive at negedge, check osc_n, step model at posedge, compare
  task automatic cyc(input bit o, input bit e, input bit s, input bit rq);
    bit t;
    @(negedge clk);
    osc = o; ext = e; sel = s; req_n = rq;
    #1;
    t = sel_tick(s, o, e);
    chk(osc_n == ~t, "R7 osc_n", osc_n, ~t);
    @(posedge clk);
    model_step(t, rq);
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; osc = 0; ext = 0; req_n = 1;
    model_reset();
    repeat (2) @(negedge clk);
    chk(cclk == 0 && pclk == 0, "R9 clocks low", {cclk, pclk}, 0);
    chk({crise, cfall, prise, pfall} == 4'b0, "R9 strobes low", {crise, cfall, prise, pfall}, 0);
    chk(crst == 1, "R9 cpu_rst high", crst, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rises;
    bit seen;
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // release reset request, run oscillator every cycle (R2, R5)
    repeat (40) cyc(1, 0, 0, 1);
    chk(crst == 0, "R5 reset released", crst, 0);

    // R1: external ticks alone while oscillator selected: nothing moves
    begin
      bit c0, p0;
      c0 = cclk; p0 = pclk;
      repeat (12) cyc(0, 1, 0, 1);
      chk(cclk == c0 && pclk == p0, "R1 unselected ext ignored", {cclk, pclk}, {c0, p0});
      repeat (12) cyc(1, 0, 1, 1);
      chk(cclk == c0 && pclk == p0, "R1 unselected osc ignored", {cclk, pclk}, {c0, p0});
    end

    // R8: align to a rise, two osc ticks, switch to ext, one ext tick => rise
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      cyc(1, 0, 0, 1);
      seen = crise;
    end
    cyc(1, 0, 0, 1);
    cyc(1, 0, 0, 1);
    cyc(0, 0, 1, 1);
    chk(crise == 0, "R8 no rise on switch", crise, 0);
    cyc(0, 1, 1, 1);
    chk(crise == 1, "R8 count continues across switch", crise, 1);

    // R6: assert request, count rises until cpu_rst high
    rises = 0;
    for (int i = 0; i < 40 && crst == 0; i++) begin
      cyc(0, 1, 1, 0);
      if (crise) rises++;
    end
    chk(crst == 1 && rises <= 4, "R6 reset within four clocks", rises, 4);
    repeat (20) cyc(0, 1, 1, 1);

    // random run: sparse and dense ticks, select and request changes
    begin
      bit s, rq;
      s = 0; rq = 1;
      for (int i = 0; i < 6000; i++) begin
        bit o, e;
        if ($urandom_range(0, 99) < 3) s = ~s;
        if ($urandom_range(0, 199) < 2) rq = ~rq;
        o = ($urandom_range(0, 3) != 0);
        e = ($urandom_range(0, 2) == 0);
        cyc(o, e, s, rq);
      end
    end

    // R9: reset again mid-operation, then resume
    do_reset();
    repeat (30) cyc(1, 1, 0, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule